// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block decides which analog input an external converter samples next. A channel enable mask selects up to eight inputs. On each result request the sequencer starts one conversion on the next enabled channel, in ascending order. After the highest enabled channel it returns to the lowest enabled one, and this repeats without end. When the converter returns its 12-bit sample, the block tags it with a 4-bit channel identifier and presents the 16-bit word together with a validity flag.

Loading a new mask abandons any conversion still pending. The next conversion after the load uses the lowest channel that the new mask enables. If the mask is all zeros, requests start nothing: the last word stays on the output and is marked invalid. The converter sits outside the block and talks to it through a start pulse and a ready strobe.

Top module: `conv_sequencer`

## Requirements
- R1: While `rst` is high and after it is released, `conv_start`, `ch_sel`, `result` and `result_valid` are all zero and the mask is empty.
- R2: The mask is read MSB-first: channel c is enabled by `mask_in` bit (7-c). Loading 0xE0 enables channels 0, 1 and 2 only, and `conv_start` is only ever raised for an enabled channel.
- R3: Successive conversions use the enabled channels in ascending order.
- R4: After the highest enabled channel, the next conversion is the lowest enabled channel. A mask with a single enabled channel converts that channel every time.
- R5: A `mask_load` abandons any pending conversion, and a `smp_ready` that arrives later for it does not change `result`. The next conversion is the lowest enabled channel of the new mask. A `next_req` in the same cycle as `mask_load` is ignored.
- R6: On a `smp_ready` for a pending conversion, `result` becomes {channel number zero-extended to 4 bits in bits 15:12, `smp_data` in bits 11:0} one cycle later, and `result_valid` becomes 1.
- R7: A `next_req` sampled with a non-empty mask and nothing pending raises `conv_start` for exactly the following cycle. `ch_sel` shows the chosen channel from that cycle until the next conversion starts.
- R8: With an all-zero mask, `next_req` starts no conversion, clears `result_valid` one cycle later and leaves `result` unchanged.
- R9: A `next_req` while a conversion is pending is ignored.
- R10: A `smp_ready` when no conversion is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_in | input | 8 | Channel enable mask, MSB is channel 0 |
| mask_load | input | 1 | Loads `mask_in` and restarts the sequence |
| next_req | input | 1 | Request for the next result |
| smp_ready | input | 1 | Converter strobe: `smp_data` is valid |
| smp_data | input | 12 | Converter sample |
| ch_sel | output | 3 | Channel being converted |
| conv_start | output | 1 | One-cycle conversion start pulse |
| result | output | 16 | Channel tag in 15:12, sample in 11:0 |
| result_valid | output | 1 | Result word is valid |

## Verification
The assertions assume that the converter raises `smp_ready` for one cycle per start pulse and keeps `smp_data` steady during that cycle. They also assume that `next_req` and `mask_load` are synchronous to `clk`. The bench's converter stub follows these rules with a programmable latency. Where the stimulus breaks them on purpose (stray ready strobes, a ready that arrives after its conversion was abandoned, requests during a pending conversion), it does so only to exercise the cases where the block must ignore the input.

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 12,
  parameter int ID_W   = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int WORD_W = ID_W + RES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] mask_in,
  input  logic              mask_load,
  input  logic              next_req,
  input  logic              smp_ready,
  input  logic [RES_W-1:0]  smp_data,
  output logic [CH_W-1:0]   ch_sel,
  output logic              conv_start,
  output logic [WORD_W-1:0] result,
  output logic              result_valid
);

  logic [NUM_CH-1:0] en_in, en_r;
  logic [CH_W-1:0]   nxt_r, ch_r;
  logic              start_r, busy_r, valid_r;
  logic [WORD_W-1:0] word_r;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rev
    assign en_in[c] = mask_in[NUM_CH-1-c];
  end

  function automatic logic [CH_W-1:0] scan(input logic [NUM_CH-1:0] en,
                                           input logic [CH_W-1:0] from);
    logic            found;
    logic [CH_W-1:0] c;
    scan  = from;
    found = 1'b0;
    for (int k = 1; k <= NUM_CH; k++) begin
      c = CH_W'((int'(from) + k) % NUM_CH);
      if (!found && en[c]) begin
        scan  = c;
        found = 1'b1;
      end
    end
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r    <= '0;
      nxt_r   <= '0;
      ch_r    <= '0;
      start_r <= 1'b0;
      busy_r  <= 1'b0;
      word_r  <= '0;
      valid_r <= 1'b0;
    end else begin
      start_r <= 1'b0;
      if (mask_load) begin
        en_r   <= en_in;
        nxt_r  <= scan(en_in, CH_W'(NUM_CH - 1));
        busy_r <= 1'b0;
      end else if (busy_r) begin
        if (smp_ready) begin
          word_r  <= {ID_W'(ch_r), smp_data};
          valid_r <= 1'b1;
          busy_r  <= 1'b0;
        end
      end else if (next_req) begin
        if (|en_r) begin
          ch_r    <= nxt_r;
          start_r <= 1'b1;
          busy_r  <= 1'b1;
          nxt_r   <= scan(en_r, nxt_r);
        end else begin
          valid_r <= 1'b0;
        end
      end
    end
  end

  assign ch_sel       = ch_r;
  assign conv_start   = start_r;
  assign result       = word_r;
  assign result_valid = valid_r;

  assert_start_single_R7: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  assert_start_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> en_r[ch_sel]);

  assert_load_cancels_R5: assert property (@(posedge clk) disable iff (rst)
    mask_load |=> !conv_start);

  assert_pending_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    busy_r |=> !conv_start);

  assert_empty_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (en_r == '0 && next_req && !mask_load) |=> (!conv_start && !result_valid && $stable(result)));

  assert_tagged_word_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_r && smp_ready && !mask_load) |=>
      (result_valid && result[WORD_W-1:RES_W] == ID_W'($past(ch_sel))));

endmodule

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mask_in = '0;
  logic        mask_load = 1'b0;
  logic        next_req = 1'b0;
  logic        smp_ready = 1'b0;
  logic [11:0] smp_data = '0;
  logic [2:0]  ch_sel;
  logic        conv_start;
  logic [15:0] result;
  logic        result_valid;

  int total = 0, bad = 0;
  string cur = "R1";

  conv_sequencer u_conv_sequencer (
    .clk(clk), .rst(rst), .mask_in(mask_in), .mask_load(mask_load),
    .next_req(next_req), .smp_ready(smp_ready), .smp_data(smp_data),
    .ch_sel(ch_sel), .conv_start(conv_start), .result(result),
    .result_valid(result_valid));

  always #5 clk = ~clk;

  // behavioural reference
  bit          m_en[8];
  int          m_next, m_ch;
  bit          m_busy, m_start, m_val;
  logic [15:0] m_res;

  function automatic int first_after(int from);
    for (int k = 1; k <= 8; k++) begin
      if (m_en[(from + k) % 8]) return (from + k) % 8;
    end
    return from;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_en[i]) m_en[i] = 0;
      m_next = 0; m_ch = 0; m_busy = 0; m_start = 0; m_val = 0; m_res = '0;
    end else begin
      bit any;
      m_start = 0;
      any = 0;
      foreach (m_en[i]) any |= m_en[i];
      if (mask_load) begin
        for (int c = 0; c < 8; c++) m_en[c] = mask_in[7-c];
        m_next = first_after(7);
        m_busy = 0;
      end else if (m_busy) begin
        if (smp_ready) begin
          m_res = {4'(m_ch), smp_data};
          m_val = 1;
          m_busy = 0;
        end
      end else if (next_req) begin
        if (any) begin
          m_ch = m_next; m_start = 1; m_busy = 1;
          m_next = first_after(m_next);
        end else m_val = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // converter stub
  int lat = 1, cnt = 0, starts = 0;
  logic [11:0] last_data = '0;
  int samp_n = 0;

  task automatic cyc();
    @(negedge clk);
    chk(conv_start == m_start, {cur, " start"}, 32'(conv_start), 32'(m_start));
    chk(ch_sel == 3'(m_ch), {cur, " ch_sel"}, 32'(ch_sel), 32'(m_ch));
    chk(result == m_res, {cur, " result"}, 32'(result), 32'(m_res));
    chk(result_valid == m_val, {cur, " valid"}, 32'(result_valid), 32'(m_val));
    smp_ready = 1'b0;
    if (conv_start) begin
      starts++;
      cnt = lat;
    end
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        samp_n++;
        last_data = 12'(int'(ch_sel) * 256 + samp_n);
        smp_data = last_data;
        smp_ready = 1'b1;
      end
    end
  endtask

  task automatic load(input logic [7:0] m);
    mask_in = m; mask_load = 1'b1;
    cyc();
    mask_load = 1'b0;
  endtask

  task automatic request();
    next_req = 1'b1;
    cyc();
    next_req = 1'b0;
  endtask

  task automatic get(input int ch, input string req);
    request();
    repeat (lat + 1) cyc();
    chk(result[15:12] == 4'(ch), req, 32'(result[15:12]), 32'(ch));
    chk(result_valid == 1'b1, req, 32'(result_valid), 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    int s0;
    repeat (3) cyc();
    cur = "R1";
    chk(result == 16'h0 && !result_valid && !conv_start && ch_sel == 3'd0, "R1 reset", 32'(result), 32'h0);
    rst = 1'b0;
    cyc();
    request();
    cyc();
    chk(starts == 0, "R1 empty mask after reset", 32'(starts), 32'd0);

    cur = "R2";
    load(8'hE0);
    get(0, "R2 first of 0xE0");
    chk(result[11:0] == last_data, "R6 sample field", 32'(result[11:0]), 32'(last_data));
    cur = "R3";
    get(1, "R3 ascending");
    get(2, "R3 ascending");
    cur = "R4";
    get(0, "R4 wrap");
    get(1, "R4 repeat");

    load(8'h81);
    get(0, "R4 low end");
    get(7, "R4 high end");
    get(0, "R4 wrap past 7");
    load(8'h10);
    get(3, "R4 single channel");
    get(3, "R4 single channel again");

    cur = "R6";
    lat = 3;
    load(8'h05);
    get(5, "R6 tag 5");
    chk(result == {4'd5, last_data}, "R6 full word", 32'(result), 32'({4'd5, last_data}));
    get(7, "R6 tag 7");

    cur = "R5";
    load(8'hE0);
    get(0, "R5 before abandon");
    held = result;
    request();
    load(8'h24);
    repeat (4) cyc();
    chk(result == held, "R5 late sample dropped", 32'(result), 32'(held));
    lat = 1;
    get(2, "R5 first of new mask");
    get(5, "R5 second of new mask");
    s0 = starts;
    mask_in = 8'hE0; mask_load = 1'b1; next_req = 1'b1;
    cyc();
    mask_load = 1'b0; next_req = 1'b0;
    cyc();
    chk(starts == s0, "R5 request with load ignored", 32'(starts - s0), 32'd0);
    get(0, "R5 restart at lowest");

    cur = "R9";
    lat = 5;
    s0 = starts;
    request();
    request();
    request();
    repeat (5) cyc();
    chk(starts - s0 == 1, "R9 single start", 32'(starts - s0), 32'd1);
    chk(result[15:12] == 4'd1, "R9 channel", 32'(result[15:12]), 32'd1);
    lat = 1;

    cur = "R10";
    held = result;
    smp_data = 12'hABC; smp_ready = 1'b1;
    cyc();
    cyc();
    chk(result == held, "R10 stray ready", 32'(result), 32'(held));

    cur = "R7";
    s0 = starts;
    request();
    chk(conv_start == 1'b1 && ch_sel == 3'd2, "R7 pulse and channel", 32'({conv_start, ch_sel}), 32'h1_2);
    cyc();
    chk(conv_start == 1'b0 && ch_sel == 3'd2, "R7 pulse ends, channel held", 32'({conv_start, ch_sel}), 32'h0_2);
    cyc();

    cur = "R8";
    held = result;
    load(8'h00);
    s0 = starts;
    request();
    cyc();
    chk(result_valid == 1'b0, "R8 invalid flag", 32'(result_valid), 32'd0);
    chk(result == held, "R8 word held", 32'(result), 32'(held));
    chk(starts == s0, "R8 no start", 32'(starts - s0), 32'd0);

    repeat (3) cyc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule